// File: doc/BRIEF.md
# Virtual Interrupt Preemption Signaller

This block decides, once per clock, whether the pending virtual interrupt chosen by an upstream selector may be raised to the processor. If it may, the block drives the matching virtual interrupt line. A group-0 candidate goes out on the fast line (vFIQ). A group-1 candidate goes out on the normal line (vIRQ).

The decision uses these inputs:
- the virtual interface enable;
- the virtual priority mask;
- the priority of the interrupt currently running, where all ones means nothing is running;
- one binary-point value per group.

Each binary-point value yields a group-priority mask. A candidate preempts a running interrupt only on its group-priority bits. Its subpriority bits take no part in the comparison.

The result is held in a three-state register: `SIG_NONE`, `SIG_FIQ` and `SIG_IRQ`. The register takes a new state every cycle from the current inputs, and any state may move to any other in one step. There are three kinds of transition:
- *raise*: from `SIG_NONE` to a line state;
- *drop*: from a line state back to `SIG_NONE`;
- *swap*: from `SIG_FIQ` to `SIG_IRQ`, or the reverse.

Reset forces `SIG_NONE`. The output lines are decoded from the state alone.

Top module: `vps_signaller`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after reset, both `virq_o` and `vfiq_o` are 0.
- R2: When `vif_en_i` is 0, neither output is asserted, whatever the other inputs are.
- R3: A candidate whose priority is greater than or equal to `vpmr_i` is not signalled. A priority one below `vpmr_i` is not masked.
- R4: When `act_prio_i` is 8'hFF, meaning nothing is running, any enabled and unmasked candidate is signalled.
- R5: When something is running, the candidate is signalled only if (priority AND group mask) < (active priority AND group mask). Differences in the masked-off subpriority bits have no effect.
- R6: The group mask for a binary-point value b is 8'hFF shifted left by b+1, so it clears the low b+1 bits. The mask used is the one for the candidate's own group: `bp_g0_i` when `cand_grp_i`=0, and `bp_g1_i` when `cand_grp_i`=1. A value of 7 gives a mask of zero.
- R7: A signalled candidate with `cand_grp_i`=0 drives `vfiq_o`. A signalled candidate with `cand_grp_i`=1 drives `virq_o`.
- R8: At most one of `virq_o` and `vfiq_o` is high in any cycle. Both are low when `cand_valid_i` is 0.
- R9: The outputs are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vif_en_i | input | 1 | Virtual interface enable |
| cand_valid_i | input | 1 | Selector reports a pending candidate |
| cand_grp_i | input | 1 | Candidate group (0 or 1) |
| cand_prio_i | input | 8 | Candidate priority, lower value is more urgent |
| vpmr_i | input | 8 | Virtual priority mask |
| bp_g0_i | input | 3 | Binary point for group 0 |
| bp_g1_i | input | 3 | Binary point for group 1 |
| act_prio_i | input | 8 | Highest active virtual priority, 8'hFF when idle |
| virq_o | output | 1 | Virtual IRQ level |
| vfiq_o | output | 1 | Virtual FIQ level |

## Verification
A wrong state in the register appears on the output lines in the very next sampled cycle. The causes differ:
- a raise taken against a closed enable or against the priority mask;
- a swap to the wrong line;
- a drop missed when the selector goes empty.

Because the state is rebuilt every cycle, a fault never persists beyond the vector that provokes it, so each table row isolates one decision. The mask cases sit on exact equality and exact one-below boundaries, and the binary-point cases use values for which the two group masks would give opposite answers. Between them, these catch a swapped mask, an off-by-one shift or a comparison that uses <= instead of <.

// File: rtl/vps_pkg.sv
package vps_pkg;

    // Signalling state, one line at most
    typedef enum logic [1:0] {
        SIG_NONE = 2'b00,
        SIG_FIQ  = 2'b01,
        SIG_IRQ  = 2'b10
    } sig_state_e;

    localparam int NUM_GRP = 2;

endpackage

// File: rtl/vps_gmask.sv
module vps_gmask #(
    parameter int PRIO_W = 8,
    parameter int BP_W   = 3
) (
    input  logic [BP_W-1:0]   bp_i,
    output logic [PRIO_W-1:0] mask_o
);
    localparam int SH_W = BP_W + 1;

    logic [SH_W-1:0] shamt;

    always_comb begin
        shamt  = {1'b0, bp_i} + SH_W'(1);
        mask_o = {PRIO_W{1'b1}} << shamt;
    end
endmodule

// File: rtl/vps_decide.sv
module vps_decide
    import vps_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              en_i,
    input  logic              valid_i,
    input  logic              grp_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0] pmr_i,
    input  logic [PRIO_W-1:0] gmask_i,
    input  logic [PRIO_W-1:0] act_i,
    output sig_state_e        next_o
);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = {PRIO_W{1'b1}};

    logic       may_send;
    sig_state_e line_st;

    always_comb begin
        line_st = grp_i ? SIG_IRQ : SIG_FIQ;
        if (!en_i || !valid_i) begin
            may_send = 1'b0;
        end else if (prio_i >= pmr_i) begin
            may_send = 1'b0;
        end else if (act_i == IDLE_PRIO) begin
            may_send = 1'b1;
        end else begin
            may_send = (prio_i & gmask_i) < (act_i & gmask_i);
        end
        next_o = may_send ? line_st : SIG_NONE;
    end
endmodule

// File: rtl/vps_signaller.sv
module vps_signaller
    import vps_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int BP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vif_en_i,
    input  logic              cand_valid_i,
    input  logic              cand_grp_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [PRIO_W-1:0] vpmr_i,
    input  logic [BP_W-1:0]   bp_g0_i,
    input  logic [BP_W-1:0]   bp_g1_i,
    input  logic [PRIO_W-1:0] act_prio_i,
    output logic              virq_o,
    output logic              vfiq_o
);
    logic [BP_W-1:0]   bp_arr   [NUM_GRP];
    logic [PRIO_W-1:0] mask_arr [NUM_GRP];
    logic [PRIO_W-1:0] sel_mask;
    sig_state_e        state_q;
    sig_state_e        state_d;

    assign bp_arr[0] = bp_g0_i;
    assign bp_arr[1] = bp_g1_i;

    // One group-priority mask per group (R6)
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
        vps_gmask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) mask_i (
            .bp_i   (bp_arr[g]),
            .mask_o (mask_arr[g])
        );
    end

    assign sel_mask = mask_arr[cand_grp_i];

    vps_decide #(.PRIO_W(PRIO_W)) decide_i (
        .en_i    (vif_en_i),
        .valid_i (cand_valid_i),
        .grp_i   (cand_grp_i),
        .prio_i  (cand_prio_i),
        .pmr_i   (vpmr_i),
        .gmask_i (sel_mask),
        .act_i   (act_prio_i),
        .next_o  (state_d)
    );

    // State register (R1, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SIG_NONE;
        else        state_q <= state_d;
    end

    // Output decode (R7, R8)
    always_comb begin
        virq_o = 1'b0;
        vfiq_o = 1'b0;
        unique case (state_q)
            SIG_NONE: ;
            SIG_FIQ:  vfiq_o = 1'b1;
            SIG_IRQ:  virq_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/vps_signaller_chk.sv
module vps_signaller_chk #(
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vif_en_i,
    input logic              cand_valid_i,
    input logic              cand_grp_i,
    input logic [PRIO_W-1:0] cand_prio_i,
    input logic [PRIO_W-1:0] vpmr_i,
    input logic [PRIO_W-1:0] act_prio_i,
    input logic              virq_o,
    input logic              vfiq_o
);
    a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({virq_o, vfiq_o}));

    a_r8_no_cand: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid_i |=> !virq_o && !vfiq_o);

    a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !vif_en_i |=> !virq_o && !vfiq_o);

    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_prio_i >= vpmr_i) |=> !virq_o && !vfiq_o);

    a_r4_idle_send: assert property (@(posedge clk) disable iff (!rst_n)
        (vif_en_i && cand_valid_i && cand_prio_i < vpmr_i &&
         act_prio_i == {PRIO_W{1'b1}}) |=> (virq_o || vfiq_o));

    a_r7_grp0_not_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_grp_i |=> !virq_o);

    a_r7_grp1_not_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        cand_grp_i |=> !vfiq_o);
endmodule

bind vps_signaller vps_signaller_chk #(.PRIO_W(PRIO_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vif_en_i     (vif_en_i),
    .cand_valid_i (cand_valid_i),
    .cand_grp_i   (cand_grp_i),
    .cand_prio_i  (cand_prio_i),
    .vpmr_i       (vpmr_i),
    .act_prio_i   (act_prio_i),
    .virq_o       (virq_o),
    .vfiq_o       (vfiq_o)
);

// File: tb/vps_signaller_tb.sv
module vps_signaller_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] req;
        logic       en;
        logic       valid;
        logic       grp;
        logic [7:0] prio;
        logic [7:0] pmr;
        logic [2:0] bp0;
        logic [2:0] bp1;
        logic [7:0] act;
        logic       eirq;
        logic       efiq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd4, 1'b1, 1'b1, 1'b0, 8'h40, 8'hF0, 3'd2, 3'd2, 8'hFF, 1'b0, 1'b1}, // R4 R7 grp0 -> fiq
        '{4'd7, 1'b1, 1'b1, 1'b1, 8'h40, 8'hF0, 3'd2, 3'd2, 8'hFF, 1'b1, 1'b0}, // R7 swap to irq
        '{4'd2, 1'b0, 1'b1, 1'b1, 8'h40, 8'hF0, 3'd2, 3'd2, 8'hFF, 1'b0, 1'b0}, // R2 disabled
        '{4'd3, 1'b1, 1'b1, 1'b1, 8'h80, 8'h80, 3'd2, 3'd2, 8'hFF, 1'b0, 1'b0}, // R3 equal masked
        '{4'd3, 1'b1, 1'b1, 1'b1, 8'h7F, 8'h80, 3'd2, 3'd2, 8'hFF, 1'b1, 1'b0}, // R3 one below
        '{4'd8, 1'b1, 1'b0, 1'b1, 8'h10, 8'hF0, 3'd2, 3'd2, 8'hFF, 1'b0, 1'b0}, // R8 no candidate
        '{4'd5, 1'b1, 1'b1, 1'b1, 8'h20, 8'hFF, 3'd2, 3'd3, 8'h30, 1'b1, 1'b0}, // R5 preempt
        '{4'd5, 1'b1, 1'b1, 1'b1, 8'h38, 8'hFF, 3'd2, 3'd3, 8'h30, 1'b0, 1'b0}, // R5 same group prio
        '{4'd5, 1'b1, 1'b1, 1'b1, 8'h2F, 8'hFF, 3'd2, 3'd3, 8'h30, 1'b1, 1'b0}, // R5 subprio ignored
        '{4'd6, 1'b1, 1'b1, 1'b0, 8'h38, 8'hFF, 3'd6, 3'd0, 8'h40, 1'b0, 1'b0}, // R6 grp0 coarse mask
        '{4'd6, 1'b1, 1'b1, 1'b1, 8'h38, 8'hFF, 3'd6, 3'd0, 8'h40, 1'b1, 1'b0}, // R6 grp1 fine mask
        '{4'd6, 1'b1, 1'b1, 1'b0, 8'h38, 8'hFF, 3'd0, 3'd6, 8'h40, 1'b0, 1'b1}, // R6 grp0 fine mask
        '{4'd6, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 3'd7, 3'd0, 8'h10, 1'b0, 1'b0}, // R6 bp 7 mask zero
        '{4'd3, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0, 3'd0, 8'hFF, 1'b0, 1'b0}, // R3 mask zero
        '{4'd5, 1'b1, 1'b1, 1'b0, 8'h10, 8'hFF, 3'd0, 3'd0, 8'h10, 1'b0, 1'b0}, // R5 equal active
        '{4'd4, 1'b1, 1'b1, 1'b0, 8'hFE, 8'hFF, 3'd0, 3'd0, 8'hFF, 1'b0, 1'b1}  // R4 lowest unmasked
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vif_en_i = 1'b0;
    logic       cand_valid_i = 1'b0;
    logic       cand_grp_i = 1'b0;
    logic [7:0] cand_prio_i = 8'h00;
    logic [7:0] vpmr_i = 8'h00;
    logic [2:0] bp_g0_i = 3'd0;
    logic [2:0] bp_g1_i = 3'd0;
    logic [7:0] act_prio_i = 8'hFF;
    logic       virq_o;
    logic       vfiq_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vps_signaller dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .vif_en_i     (vif_en_i),
        .cand_valid_i (cand_valid_i),
        .cand_grp_i   (cand_grp_i),
        .cand_prio_i  (cand_prio_i),
        .vpmr_i       (vpmr_i),
        .bp_g0_i      (bp_g0_i),
        .bp_g1_i      (bp_g1_i),
        .act_prio_i   (act_prio_i),
        .virq_o       (virq_o),
        .vfiq_o       (vfiq_o)
    );

    task automatic check(input string req, input logic ei, input logic ef);
        checks++;
        if (virq_o !== ei || vfiq_o !== ef) begin
            errors++;
            $display("FAIL %s: got irq=%b fiq=%b, expected irq=%b fiq=%b",
                     req, virq_o, vfiq_o, ei, ef);
        end
    endtask

    task automatic apply(input vec_t v);
        vif_en_i     = v.en;
        cand_valid_i = v.valid;
        cand_grp_i   = v.grp;
        cand_prio_i  = v.prio;
        vpmr_i       = v.pmr;
        bp_g0_i      = v.bp0;
        bp_g1_i      = v.bp1;
        act_prio_i   = v.act;
    endtask

    initial begin
        // R1: outputs low in reset
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0);
        apply(VECS[0]);
        @(negedge clk);
        check("R1 reset holds with candidate", 1'b0, 1'b0);
        rst_n = 1'b1;
        apply('0);
        vif_en_i = 1'b0;
        @(negedge clk);
        check("R1 first cycle after reset", 1'b0, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].eirq, VECS[i].efiq);
        end

        // R9: new inputs have no effect before the next edge
        apply(VECS[1]);
        @(negedge clk);
        check("R9 settle irq", 1'b1, 1'b0);
        apply(VECS[0]);
        #1;
        check("R9 held until edge", 1'b1, 1'b0);
        @(negedge clk);
        check("R9 swapped after edge", 1'b0, 1'b1);

        // R8: selector empties, line drops in one cycle
        cand_valid_i = 1'b0;
        @(negedge clk);
        check("R8 drop on empty selector", 1'b0, 1'b0);

        // R2: enable clears a running fiq
        apply(VECS[0]);
        @(negedge clk);
        vif_en_i = 1'b0;
        @(negedge clk);
        check("R2 enable cleared", 1'b0, 1'b0);

        // R1: reset mid-run clears a raised line
        apply(VECS[1]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule